// File: doc/BRIEF.md
# Parallel Input Port Read Handshake Controller

This block runs an automatic receive handshake between a peripheral and a CPU over one parallel input port. The peripheral announces fresh data by toggling a ready line. The block synchronises that line, detects the chosen edge, sets a pending flag and, if latching is enabled, captures the port pins into a holding register. The flag can raise an active-low interrupt or be polled. The CPU then reads the port register. That read clears the flag and pulls the taken line low towards the peripheral, which may then present the next word.

The CPU side is a small register interface with four addresses: port data, flag, interrupt enable and control. The control register picks three things: whether taken is a one-cycle pulse or a level held until the next ready edge, which ready edge is active, and whether port reads return captured or live data.

Top module: `inport_handshake`

## Requirements
- R1: After reset, taken_o is 1, irq_n is 1, and the flag (address 1, bit 0), enable (address 2, bit 0) and control (address 3, bits 2:0) registers all read 0.
- R2: The ready line passes through SYNC_STAGES flip-flops before edge detection. With control bit 1 = 0 only a falling edge sets the flag, and with control bit 1 = 1 only a rising edge does. The flag is readable SYNC_STAGES+1 clocks after the input changes, and the opposite edge leaves it unchanged.
- R3: With control bit 2 = 1, the port pins are captured on each active ready edge, and a read of address 0 returns the captured word. With control bit 2 = 0, a read of address 0 returns the live pins.
- R4: A read of address 0 clears the flag.
- R5: A write to address 1 with data bit 0 = 1 clears the flag. With bit 0 = 0 the write leaves the flag unchanged.
- R6: When an active ready edge and a flag clear fall in the same cycle, the flag ends up set.
- R7: irq_n is 0 exactly when the flag is set and the enable bit is 1. The enable bit never stops the flag from setting.
- R8: A read of address 0 drives taken_o to 0 from the next clock edge.
- R9: With control bit 0 = 1 (pulse mode), taken_o stays low for exactly one clock after a port read and then returns to 1.
- R10: With control bit 0 = 0 (level mode), taken_o stays low after a port read until the next active ready edge. It returns to 1 on the same clock on which that edge sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | DATA_W | Parallel input pins from the peripheral |
| rdy_in | input | 1 | Data ready line from the peripheral (asynchronous) |
| taken_o | output | 1 | Data taken line to the peripheral, idle high |
| irq_n | output | 1 | Active-low interrupt request |
| bus_addr | input | 2 | Register select: 0 port, 1 flag, 2 enable, 3 control |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 3 | Write data |
| bus_rdata | output | DATA_W | Combinational read data for the selected register |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2. It takes the synchroniser depth from the same parameter it passes in, so every flag and taken latency check lands on the exact clock that the depth predicts. An eight-bit port lets distinct captured and live words be told apart. Two stages keep the collision of an edge with a clear reachable with a short, exact delay.

// File: rtl/inport_hs_pkg.sv
package inport_hs_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_FLAG = 2'd1,
    REG_IEN  = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int CTRL_W = 3;

  typedef struct packed {
    logic latch_en;
    logic rise_sel;
    logic pulse_mode;
  } ctrl_t;
endpackage

// File: rtl/hs_edge_detect.sv
module hs_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic evt
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              synced;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign synced = sync_q[STAGES-1];
  assign evt    = rise_sel ? (synced & ~last_q) : (~synced & last_q);
endmodule

// File: rtl/hs_capture.sv
module hs_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] hold
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (cap_en) hold_q <= din;
  end

  assign hold = hold_q;
endmodule

// File: rtl/hs_taken_seq.sv
module hs_taken_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_mode,
  input  logic port_rd,
  input  logic rdy_evt,
  output logic taken
);
  logic taken_q;
  logic taken_d;

  always_comb begin
    taken_d = taken_q;
    if (port_rd)         taken_d = 1'b0;
    else if (pulse_mode) taken_d = 1'b1;
    else if (rdy_evt)    taken_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken_q <= 1'b1;
    else        taken_q <= taken_d;
  end

  assign taken = taken_q;
endmodule

// File: rtl/inport_handshake.sv
module inport_handshake
  import inport_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] port_in,
  input  logic              rdy_in,
  output logic              taken_o,
  output logic              irq_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAD_W = DATA_W - 1;
  localparam int CPAD_W = DATA_W - CTRL_W;

  ctrl_t             ctrl_q, ctrl_d;
  logic              ien_q, ien_d;
  logic              flag_q, flag_d;
  logic              rdy_evt;
  logic              port_rd;
  logic              flag_clr;
  logic              cap_en;
  logic [DATA_W-1:0] hold_q;
  logic              pulse_mode, latch_en;

  assign pulse_mode = ctrl_q.pulse_mode;
  assign latch_en   = ctrl_q.latch_en;

  hs_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(rdy_in),
    .rise_sel(ctrl_q.rise_sel), .evt(rdy_evt)
  );

  assign cap_en = rdy_evt & latch_en;

  hs_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .din(port_in), .hold(hold_q)
  );

  assign port_rd = bus_rd && (reg_sel_e'(bus_addr) == REG_PORT);

  hs_taken_seq u_taken (
    .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode),
    .port_rd(port_rd), .rdy_evt(rdy_evt), .taken(taken_o)
  );

  always_comb begin
    flag_clr = port_rd ||
               (bus_wr && (reg_sel_e'(bus_addr) == REG_FLAG) && bus_wdata[0]);
    flag_d   = rdy_evt | (flag_q & ~flag_clr);
    ien_d    = ien_q;
    ctrl_d   = ctrl_q;
    if (bus_wr && (reg_sel_e'(bus_addr) == REG_IEN))  ien_d  = bus_wdata[0];
    if (bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL)) ctrl_d = ctrl_t'(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      flag_q <= flag_d;
      ien_q  <= ien_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign irq_n = ~(flag_q & ien_q);

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_PORT: bus_rdata = latch_en ? hold_q : port_in;
      REG_FLAG: bus_rdata = {{PAD_W{1'b0}}, flag_q};
      REG_IEN:  bus_rdata = {{PAD_W{1'b0}}, ien_q};
      default:  bus_rdata = {{CPAD_W{1'b0}}, ctrl_q};
    endcase
  end
endmodule

// File: rtl/inport_handshake_chk.sv
module inport_handshake_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy_evt,
  input logic              flag_q,
  input logic              flag_clr,
  input logic              ien_q,
  input logic              irq_n,
  input logic              taken_o,
  input logic              port_rd,
  input logic              pulse_mode,
  input logic              latch_en,
  input logic [DATA_W-1:0] hold_q,
  input logic [DATA_W-1:0] port_in
);
  // R2, R6: an active edge always leaves the flag set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_evt |=> flag_q);

  // R4, R5: a clear with no edge empties the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !rdy_evt) |=> !flag_q);

  // R7: without enable, no interrupt
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> irq_n);

  // R3: capture takes the pins seen on the edge
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_evt && latch_en) |=> (hold_q == $past(port_in)));

  // R8: port read pulls taken low
  a_r8_read_low: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> !taken_o);

  // R9: pulse mode releases after one cycle
  a_r9_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !taken_o && !port_rd) |=> taken_o);

  // R10: level mode holds low until an edge
  a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && !taken_o && !rdy_evt) |=> !taken_o);
endmodule

bind inport_handshake inport_handshake_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_evt(rdy_evt), .flag_q(flag_q),
  .flag_clr(flag_clr), .ien_q(ien_q), .irq_n(irq_n), .taken_o(taken_o),
  .port_rd(port_rd), .pulse_mode(pulse_mode), .latch_en(latch_en),
  .hold_q(hold_q), .port_in(port_in)
);

// File: tb/inport_handshake_tb.sv
module inport_handshake_tb;
  localparam int DW   = 8;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] port_in = '0;
  logic          rdy_in = 1'b0;
  logic          taken_o, irq_n;
  logic [1:0]    bus_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0]    bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  inport_handshake #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .rdy_in(rdy_in),
    .taken_o(taken_o), .irq_n(irq_n), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [2:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    step();
    bus_rd = 1'b0;
  endtask

  function automatic logic [DW-1:0] peek_unused(input logic [DW-1:0] x);
    return x;
  endfunction

  task automatic read_flag(output logic f);
    logic [DW-1:0] d;
    bus_read(2'd1, d);
    f = d[0];
  endtask

  // change rdy and wait until the flag should be visible
  task automatic rdy_to(input logic v);
    rdy_in = v;
    repeat (SYNC + 1) step();
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check(taken_o === 1'b1, "R1 taken", taken_o, 1);
    check(irq_n === 1'b1, "R1 irq_n", irq_n, 1);
    bus_read(2'd1, d); check(d === 0, "R1 flag", d, 0);
    bus_read(2'd2, d); check(d === 0, "R1 enable", d, 0);
    bus_read(2'd3, d); check(d === 0, "R1 control", d, 0);
    check(taken_o === 1'b1, "R1 taken after non-port reads", taken_o, 1);
  endtask

  task automatic t_edge_sel();
    logic f;
    rdy_to(1'b1);
    read_flag(f); check(f === 1'b0, "R2 rising ignored in falling mode", f, 0);
    rdy_in = 1'b0;
    repeat (SYNC) step();
    read_flag(f); check(f === 1'b0, "R2 flag not before sync latency", f, 0);
    read_flag(f); check(f === 1'b1, "R2 falling edge sets flag", f, 1);
    bus_write(2'd1, 3'b001);
    bus_write(2'd3, 3'b010);
    rdy_to(1'b1);
    read_flag(f); check(f === 1'b1, "R2 rising edge sets flag", f, 1);
    bus_write(2'd1, 3'b001);
    rdy_to(1'b0);
    read_flag(f); check(f === 1'b0, "R2 falling ignored in rising mode", f, 0);
  endtask

  task automatic t_capture();
    logic [DW-1:0] d;
    bus_write(2'd3, 3'b110);
    port_in = 8'hA5;
    rdy_to(1'b1);
    port_in = 8'h3C;
    step();
    bus_read(2'd0, d); check(d === 8'hA5, "R3 captured word", d, 8'hA5);
    bus_write(2'd3, 3'b010);
    bus_read(2'd0, d); check(d === 8'h3C, "R3 live pins without latch", d, 8'h3C);
    rdy_to(1'b0);
  endtask

  task automatic t_read_clear();
    logic f;
    logic [DW-1:0] d;
    rdy_to(1'b1);
    read_flag(f); check(f === 1'b1, "R4 flag set before read", f, 1);
    bus_read(2'd0, d);
    check(taken_o === 1'b0, "R8 taken low after port read", taken_o, 0);
    read_flag(f); check(f === 1'b0, "R4 port read clears flag", f, 0);
    rdy_to(1'b0);
  endtask

  task automatic t_write_clear();
    logic f;
    rdy_to(1'b1);
    bus_write(2'd1, 3'b110);
    read_flag(f); check(f === 1'b1, "R5 write of 0 keeps flag", f, 1);
    bus_write(2'd1, 3'b001);
    read_flag(f); check(f === 1'b0, "R5 write of 1 clears flag", f, 0);
    rdy_to(1'b0);
  endtask

  task automatic t_set_wins();
    logic f;
    rdy_to(1'b1);
    rdy_in = 1'b0;
    repeat (SYNC) step();
    bus_write(2'd3, 3'b000);
    rdy_in = 1'b1;
    repeat (SYNC) step();
    bus_write(2'd3, 3'b010);
    bus_write(2'd1, 3'b001);
    read_flag(f); check(f === 1'b0, "R5 cleared before collision", f, 0);
    rdy_in = 1'b0;
    repeat (SYNC + 1) step();
    rdy_in = 1'b1;
    repeat (SYNC) step();
    bus_write(2'd1, 3'b001);
    read_flag(f); check(f === 1'b1, "R6 edge wins over clear", f, 1);
    bus_write(2'd1, 3'b001);
    rdy_to(1'b0);
  endtask

  task automatic t_irq();
    logic f;
    bus_write(2'd2, 3'b000);
    rdy_to(1'b1);
    read_flag(f); check(f === 1'b1, "R7 flag sets while disabled", f, 1);
    check(irq_n === 1'b1, "R7 no irq when disabled", irq_n, 1);
    bus_write(2'd2, 3'b001);
    check(irq_n === 1'b0, "R7 irq when enabled and flagged", irq_n, 0);
    bus_write(2'd1, 3'b001);
    check(irq_n === 1'b1, "R7 irq drops with flag", irq_n, 1);
    bus_write(2'd2, 3'b000);
    rdy_to(1'b0);
  endtask

  task automatic t_pulse();
    logic [DW-1:0] d;
    bus_write(2'd3, 3'b011);
    bus_read(2'd0, d);
    check(taken_o === 1'b0, "R9 pulse low", taken_o, 0);
    step();
    check(taken_o === 1'b1, "R9 pulse one cycle", taken_o, 1);
  endtask

  task automatic t_level();
    logic [DW-1:0] d;
    bus_write(2'd3, 3'b010);
    bus_read(2'd0, d);
    repeat (6) step();
    check(taken_o === 1'b0, "R10 level held low", taken_o, 0);
    rdy_in = 1'b1;
    repeat (SYNC) step();
    check(taken_o === 1'b0, "R10 still low before edge lands", taken_o, 0);
    step();
    check(taken_o === 1'b1, "R10 released by ready edge", taken_o, 1);
    rdy_to(1'b0);
    bus_write(2'd1, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_edge_sel();
    t_capture();
    t_read_clear();
    t_write_clear();
    t_set_wins();
    t_irq();
    t_pulse();
    t_level();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x%0h expected=0x%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule